// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences the power-down mode of a small processor core. The core raises a one-cycle strobe when it executes a sleep instruction or a watchdog-clear instruction. The block also watches a set of interrupt sources, each with an enable bit and a flag bit, plus the global interrupt enable, a watchdog timeout and an external reset. In return it gates the oscillator, pulses the watchdog clear, and keeps the two power status bits. The power-down bit `stat_pd` belongs at status bit 3 and the timeout bit `stat_to` at status bit 4 of the core's status register.

A sleep request becomes a no-op when an enabled flag is already pending in the cycle the sleep instruction executes. Otherwise the sleep takes effect in full: the watchdog is cleared and keeps running, PD falls, TO is set and the oscillator stops. Any enabled pending flag wakes the core, whatever the global enable is. So does a watchdog timeout, which is a continuation of execution and not a reset. On wake the block pulses `wake_pulse` for one cycle. It reports through `wake_kind` whether the core simply resumes at the prefetched next instruction (0) or runs that instruction and then branches to the interrupt vector at 0x0004 (1). An external reset returns the block to the running state without a wake.

The state machine has three states. RUN is normal execution. SLEEP means the oscillator is off. WAKE is one cycle with the oscillator restarted and the wake pulse high. The transitions are:
- ENTER: RUN to SLEEP, on the sleep strobe with nothing pending.
- NOP_SLEEP: RUN to RUN, on the sleep strobe with an enabled flag pending.
- IRQ_WAKE: SLEEP to WAKE, on an enabled flag.
- WDT_WAKE: SLEEP to WAKE, on a watchdog timeout.
- RESUME: WAKE to RUN.
- XRESET: any state to RUN, on external reset.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, osc_en=1, stat_pd=1, stat_to=1, wdt_clr=0, wake_pulse=0 and wake_kind=0.
- R2: A sleep strobe in RUN with no enabled pending flag takes effect at the next clock edge. From the next cycle osc_en=0, stat_pd (status bit 3)=0 and stat_to (status bit 4)=1, and wdt_clr is high for exactly that one cycle.
- R3: A sleep strobe in a cycle where some source has both its enable and flag bits at 1 is a no-op. osc_en stays 1, stat_pd and stat_to keep their values, and wdt_clr stays 0.
- R4: A flag whose enable bit is 0 neither blocks a sleep nor wakes the block. The global enable alone does not wake it either.
- R5: While asleep, a source with enable and flag both at 1 wakes the block at the next edge. osc_en returns to 1 and wake_pulse is high for exactly one cycle. Status bits are unchanged by an interrupt wake.
- R6: Wake occurs regardless of gie. wake_kind takes the value of gie in the wake cycle (0 = resume at next instruction, 1 = run next instruction then vector to 0x0004) and holds it until the next wake.
- R7: A watchdog timeout while asleep wakes the block like R5 (wake_pulse, osc_en=1) and clears stat_to, with stat_pd staying 0.
- R8: External reset has priority over every other input. The block returns to RUN with osc_en=1 at the next edge, gives no wake_pulse and leaves stat_pd and stat_to unchanged.
- R9: A clear-watchdog strobe in RUN gives a one-cycle wdt_clr pulse in the next cycle and sets both stat_pd and stat_to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_reset | input | 1 | External reset request, synchronous, highest priority |
| sleep_stb | input | 1 | One-cycle strobe: sleep instruction executes |
| clrwdt_stb | input | 1 | One-cycle strobe: watchdog-clear instruction executes |
| irq_en | input | N_SRC | Per-source interrupt enable bits |
| irq_flag | input | N_SRC | Per-source interrupt flag bits |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog timeout event |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| stat_pd | output | 1 | Power-down status bit (status bit 3) |
| stat_to | output | 1 | Timeout status bit (status bit 4) |
| wake_pulse | output | 1 | One-cycle pulse when the oscillator restarts on wake |
| wake_kind | output | 1 | 0 = resume after sleep, 1 = vector after next instruction |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. This holds for the sleep entry effects, the wake pulse, the status-bit changes, the watchdog clear pulse and the return from external reset. The results then persist or fall back one edge later. The bench drives each stimulus on a falling edge and queues the result expected after the following rising edge. Its monitor pops and compares a quarter period after that rising edge. A second idle step then checks that pulses have dropped and that levels have held.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_SLEEP = 2'd1,
        S_WAKE  = 2'd2
    } slp_state_e;

    typedef enum logic {
        WK_RESUME = 1'b0,
        WK_VECTOR = 1'b1
    } wake_kind_e;
endpackage

// File: rtl/slpw_irq_gate.sv
module slpw_irq_gate #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_flag,
    output logic             pending
);
    logic [N_SRC-1:0] armed;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign armed[g] = irq_en[g] & irq_flag[g];
    end

    assign pending = |armed;
endmodule

// File: rtl/slpw_fsm.sv
module slpw_fsm
    import slpw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_reset,
    input  logic sleep_stb,
    input  logic clrwdt_stb,
    input  logic pending,
    input  logic gie,
    input  logic wdt_timeout,
    output logic enter,
    output logic clr_req,
    output logic wdt_wake,
    output logic osc_en,
    output logic wake_pulse,
    output logic wake_kind
);
    slp_state_e state, nxt;
    wake_kind_e kind_q;
    logic       wake_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:   if (sleep_stb && !pending) nxt = S_SLEEP;
            S_SLEEP: if (pending || wdt_timeout) nxt = S_WAKE;
            S_WAKE:  nxt = S_RUN;
            default: nxt = S_RUN;
        endcase
        if (ext_reset) nxt = S_RUN;
    end

    always_comb begin
        enter      = (state == S_RUN) && sleep_stb && !pending && !ext_reset;
        clr_req    = (state == S_RUN) && clrwdt_stb && !sleep_stb && !ext_reset;
        wake_go    = (state == S_SLEEP) && (pending || wdt_timeout) && !ext_reset;
        wdt_wake   = wake_go && wdt_timeout;
        osc_en     = (state != S_SLEEP);
        wake_pulse = (state == S_WAKE);
        wake_kind  = kind_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       kind_q <= WK_RESUME;
        else if (wake_go) kind_q <= gie ? WK_VECTOR : WK_RESUME;
    end

    AST_NOP_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && sleep_stb && pending && !ext_reset) |=> osc_en); // R3
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R5
    AST_WAKE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_go |=> (wake_pulse && osc_en)); // R5
    AST_KIND_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_go |=> (wake_kind == $past(gie))); // R6
    AST_XRESET: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reset |=> (osc_en && !wake_pulse)); // R8
endmodule

// File: rtl/slpw_status.sv
module slpw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic clr_req,
    input  logic wdt_wake,
    output logic wdt_clr,
    output logic stat_pd,
    output logic stat_to
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_clr <= 1'b0;
            stat_pd <= 1'b1;
            stat_to <= 1'b1;
        end else begin
            wdt_clr <= enter | clr_req;
            if (enter) begin
                stat_pd <= 1'b0;
                stat_to <= 1'b1;
            end else if (clr_req) begin
                stat_pd <= 1'b1;
                stat_to <= 1'b1;
            end else if (wdt_wake) begin
                stat_to <= 1'b0;
            end
        end
    end

    AST_ENTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (!stat_pd && stat_to && wdt_clr)); // R2
    AST_WDT_WAKE_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_wake |=> (!stat_to && !stat_pd)); // R7
    AST_CLRWDT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (stat_pd && stat_to && wdt_clr)); // R9
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_reset,
    input  logic             sleep_stb,
    input  logic             clrwdt_stb,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_flag,
    input  logic             gie,
    input  logic             wdt_timeout,
    output logic             osc_en,
    output logic             wdt_clr,
    output logic             stat_pd,
    output logic             stat_to,
    output logic             wake_pulse,
    output logic             wake_kind
);
    logic pending;
    logic enter;
    logic clr_req;
    logic wdt_wake;

    slpw_irq_gate #(.N_SRC(N_SRC)) u_gate (
        .irq_en   (irq_en),
        .irq_flag (irq_flag),
        .pending  (pending)
    );

    slpw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_reset   (ext_reset),
        .sleep_stb   (sleep_stb),
        .clrwdt_stb  (clrwdt_stb),
        .pending     (pending),
        .gie         (gie),
        .wdt_timeout (wdt_timeout),
        .enter       (enter),
        .clr_req     (clr_req),
        .wdt_wake    (wdt_wake),
        .osc_en      (osc_en),
        .wake_pulse  (wake_pulse),
        .wake_kind   (wake_kind)
    );

    slpw_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (enter),
        .clr_req  (clr_req),
        .wdt_wake (wdt_wake),
        .wdt_clr  (wdt_clr),
        .stat_pd  (stat_pd),
        .stat_to  (stat_to)
    );

    AST_NO_WAKE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !wake_pulse && !sleep_stb) |=> !wake_pulse); // R4
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    typedef struct packed {
        logic [5:0] v;
        logic [7:0] req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_reset = 1'b0, sleep_stb = 1'b0, clrwdt_stb = 1'b0;
    logic [N-1:0] irq_en = '0, irq_flag = '0;
    logic gie = 1'b0, wdt_timeout = 1'b0;
    logic osc_en, wdt_clr, stat_pd, stat_to, wake_pulse, wake_kind;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_wake_ctrl #(.N_SRC(N)) i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_reset(ext_reset), .sleep_stb(sleep_stb),
        .clrwdt_stb(clrwdt_stb), .irq_en(irq_en), .irq_flag(irq_flag), .gie(gie),
        .wdt_timeout(wdt_timeout), .osc_en(osc_en), .wdt_clr(wdt_clr),
        .stat_pd(stat_pd), .stat_to(stat_to), .wake_pulse(wake_pulse),
        .wake_kind(wake_kind)
    );

    // Driver: inputs on the falling edge, expectation for the next rising edge.
    // Expected vector order: {osc_en, stat_pd, stat_to, wdt_clr, wake_pulse, wake_kind}
    task automatic step(input logic slp, input logic clr, input logic [N-1:0] en,
                        input logic [N-1:0] fl, input logic g, input logic wdt,
                        input logic xr, input logic [5:0] ev, input int req);
        exp_t e;
        @(negedge clk);
        sleep_stb = slp; clrwdt_stb = clr; irq_en = en; irq_flag = fl;
        gie = g; wdt_timeout = wdt; ext_reset = xr;
        e.v = ev; e.req = 8'(req);
        q.push_back(e);
    endtask

    // Monitor: pops one item a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        while (q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            e = q.pop_front();
            act = {osc_en, stat_pd, stat_to, wdt_clr, wake_pulse, wake_kind};
            n_chk++;
            if (act !== e.v) begin
                n_fail++;
                $display("FAIL R%0d: actual %b expected %b", e.req, act, e.v);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b111000, 1);  // R1 reset state
        step(1,0,4'b0001,4'b0001,0,0,0, 6'b111000, 3);  // R3 sleep with pending = no-op
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b111000, 3);  // R3
        step(1,0,4'b0001,4'b0010,0,0,0, 6'b001100, 2);  // R2 and R4: unenabled flag does not block
        step(0,0,4'b0001,4'b0010,0,0,0, 6'b001000, 4);  // R4 unenabled flag does not wake
        step(0,0,4'b0001,4'b0011,0,0,0, 6'b101010, 5);  // R5 wake, gie=0 -> resume (R6)
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b101000, 5);  // R5 pulse lasts one cycle
        step(0,1,4'b0000,4'b0000,0,0,0, 6'b111100, 9);  // R9 clear watchdog
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b111000, 9);  // R9
        step(1,0,4'b0000,4'b0000,0,0,0, 6'b001100, 2);  // R2
        step(0,0,4'b0000,4'b0000,1,0,0, 6'b001000, 4);  // R4 gie alone does not wake
        step(0,0,4'b0100,4'b0100,1,0,0, 6'b101011, 6);  // R6 wake with gie=1 -> vector
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b101001, 6);  // R6 kind held
        step(1,0,4'b0000,4'b0000,0,0,0, 6'b001101, 2);  // R2
        step(0,0,4'b0000,4'b0000,0,1,0, 6'b100010, 7);  // R7 watchdog wake clears TO
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b100000, 7);  // R7
        step(1,0,4'b1000,4'b1000,0,0,0, 6'b100000, 3);  // R3 no-op keeps PD=0, TO=0
        step(1,0,4'b0000,4'b0000,0,0,0, 6'b001100, 2);  // R2 sleep sets TO again
        step(0,0,4'b0001,4'b0001,1,0,1, 6'b101000, 8);  // R8 ext reset beats wake
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b101000, 8);  // R8 no later pulse
        step(0,1,4'b0000,4'b0000,0,0,0, 6'b111100, 9);  // R9
        step(0,0,4'b0000,4'b0000,0,0,0, 6'b111000, 9);  // R9
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule